// File: doc/BRIEF.md
# Generator Seed Assembly Unit

This unit builds the 768-bit seed that a random-bit generator loads when it reseeds. The upper 384 bits come from a personalization string held in twelve write-only words. A control bit can zero the whole string. The lower 384 bits come from one of three sources, chosen by priority: twelve write-only external seed words, a 128-bit test seed, or a 384-bit entropy input port.

The test seed is loaded serially. Each accepted write to a serial register shifts the seed left by one bit, and the unit then announces a reseed strobe followed by a regeneration strobe. A write is accepted only when test mode is on and the source is enabled. The source is enabled when it is out of its register reset, out of soft reset, has its enable bit set and has its oscillator bit set.

A revision input selects which control bits are forced to zero on a write. Reads of the seed and personalization window never return the secret words; they return the status word supplied at a port.

Top module: `seed_assembler`

## Requirements
- R1: The lower half of `seed_o` (bits 383:0) selects a source by priority. The external seed is used when CTRL bit 2 is set. Otherwise the test seed is used when CTRL bit 3 (test mode) is set. Otherwise `entropy_i` is used.
- R2: The upper half of `seed_o` (bits 767:384) is zero while CTRL bit 6 is set. Otherwise it holds the personalization words: the word at address 0x20+i sits at bits 384+32i upward.
- R3: Each accepted serial write (address 0x02) shifts the 128-bit test seed left by one and puts data bit 0 in its LSB. In the lower half of `seed_o`, the test seed occupies bits 127:0 and bits 383:128 are zero.
- R4: A serial write is accepted only when all of the following hold: CTRL bit 3 is set, CTRL bit 0 (soft reset) is clear, CTRL bit 1 (source enable) is set, bit 0 at address 0x04 (oscillator) is set, and bit 0 at address 0x03 (register reset) is clear. Any other serial write leaves the test seed unchanged and raises no strobe.
- R5: An accepted serial write raises `reseed_o` for the one cycle after its write edge, and then raises `regen_o` in the cycle after that.
- R6: A read from any address in 0x10 to 0x2F returns `status_i`. A read of address 0x01 also returns `status_i`.
- R7: With `legacy_rev_i` high, a write to CTRL (0x00) forces bits 6 and 7 to zero. With it low, the write forces bits 4 and 5 to zero instead. CTRL reads back its eight stored bits.
- R8: After `rst_n` the test seed is zero, CTRL is zero, the oscillator bit is zero, the register reset bit reads 1, the seed words are zero and no strobe is high.
- R9: The external seed word at address 0x10+i appears at bits 32i upward of the lower half when that source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| legacy_rev_i | input | 1 | High selects the older revision's control-bit masking |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Word address of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 6 | Word address of the read |
| rd_data_o | output | 32 | Read data (combinational) |
| status_i | input | 32 | Status word returned for hidden-range reads |
| entropy_i | input | 384 | Entropy source for the lowest-priority seed |
| seed_o | output | 768 | Assembled seed vector |
| reseed_o | output | 1 | One-cycle reseed strobe |
| regen_o | output | 1 | One-cycle regeneration strobe, one cycle after reseed |

## Verification
The hardest case to reach from the ports is a serial write that is blocked by exactly one of its five enabling conditions. Each gate sits in a different register, so the unit has to be set into every mixture of them. The bench sweeps all 32 combinations of the five gates. For each one it writes the register reset, oscillator and control words and then issues a serial write. It checks the strobes, and it later checks the resulting test seed bit for bit against a shift model kept in the bench.

// File: rtl/seed_pkg.sv
package seed_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int CTRL_W   = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] A_STAT   = 6'h01;
  localparam logic [ADDR_W-1:0] A_SERIAL = 6'h02;
  localparam logic [ADDR_W-1:0] A_HOLD   = 6'h03;
  localparam logic [ADDR_W-1:0] A_OSC    = 6'h04;
  localparam logic [ADDR_W-1:0] A_EXT    = 6'h10;
  localparam logic [ADDR_W-1:0] A_PERS   = 6'h20;
  localparam logic [ADDR_W-1:0] A_HIDE_LO = 6'h10;
  localparam logic [ADDR_W-1:0] A_HIDE_HI = 6'h2F;

  typedef struct packed {
    logic one_shot;    // bit 7
    logic pers_off;    // bit 6
    logic auto_adapt;  // bit 5
    logic health_en;   // bit 4
    logic test_mode;   // bit 3
    logic ext_sel;     // bit 2
    logic src_en;      // bit 1
    logic soft_rst;    // bit 0
  } ctrl_t;

  function automatic ctrl_t filter_ctrl(input logic [CTRL_W-1:0] raw,
                                        input logic legacy);
    ctrl_t c;
    c = ctrl_t'(raw);
    if (legacy) begin
      c.pers_off = 1'b0;
      c.one_shot = 1'b0;
    end else begin
      c.health_en  = 1'b0;
      c.auto_adapt = 1'b0;
    end
    return c;
  endfunction

  function automatic logic source_live(input ctrl_t c, input logic hold,
                                       input logic osc);
    return !hold && !c.soft_rst && c.src_en && osc;
  endfunction

  function automatic logic in_hidden(input logic [ADDR_W-1:0] a);
    return (a >= A_HIDE_LO) && (a <= A_HIDE_HI);
  endfunction
endpackage

// File: rtl/seed_ctl_regs.sv
module seed_ctl_regs
  import seed_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy_rev_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CTRL_W-1:0] wr_byte_i,
  output ctrl_t             ctrl_o,
  output logic              hold_o,
  output logic              osc_o,
  output logic              serial_wr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '0;
      hold_o <= 1'b1;
      osc_o  <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL: ctrl_o <= filter_ctrl(wr_byte_i, legacy_rev_i);
        A_HOLD: hold_o <= wr_byte_i[0];
        A_OSC:  osc_o  <= wr_byte_i[0];
        default: ;
      endcase
    end
  end

  assign serial_wr_o = wr_en_i && (wr_addr_i == A_SERIAL);
endmodule

// File: rtl/seed_word_bank.sv
module seed_word_bank
  import seed_pkg::*;
#(
  parameter int               WORDS = 12,
  parameter logic [ADDR_W-1:0] BASE = 6'h10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [WORD_W-1:0]       wr_data_i,
  output logic [WORDS*WORD_W-1:0] bank_o
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [ADDR_W-1:0] MY_ADDR = BASE + ADDR_W'(i);
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en_i && (wr_addr_i == MY_ADDR))
        word_q <= wr_data_i;
    end
    assign bank_o[i*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/test_shift.sv
module test_shift #(
  parameter int TEST_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept_i,
  input  logic                 bit_i,
  output logic [TEST_BITS-1:0] seed_o,
  output logic                 reseed_o,
  output logic                 regen_o
);
  function automatic logic [TEST_BITS-1:0] push_bit(
      input logic [TEST_BITS-1:0] cur, input logic b);
    return {cur[TEST_BITS-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_o   <= '0;
      reseed_o <= 1'b0;
      regen_o  <= 1'b0;
    end else begin
      reseed_o <= accept_i;
      regen_o  <= reseed_o;
      if (accept_i) seed_o <= push_bit(seed_o, bit_i);
    end
  end
endmodule

// File: rtl/seed_mux.sv
module seed_mux
  import seed_pkg::*;
#(
  parameter int HALF_WORDS = 12,
  parameter int TEST_BITS  = 128,
  localparam int HALF_W    = HALF_WORDS * WORD_W
) (
  input  ctrl_t                ctrl_i,
  input  logic [HALF_W-1:0]    ext_i,
  input  logic [HALF_W-1:0]    pers_i,
  input  logic [TEST_BITS-1:0] test_i,
  input  logic [HALF_W-1:0]    entropy_i,
  output logic [2*HALF_W-1:0]  seed_o
);
  function automatic logic [HALF_W-1:0] pick_low(
      input ctrl_t c, input logic [HALF_W-1:0] ext,
      input logic [TEST_BITS-1:0] tst, input logic [HALF_W-1:0] ent);
    if (c.ext_sel)        return ext;
    else if (c.test_mode) return {{(HALF_W-TEST_BITS){1'b0}}, tst};
    else                  return ent;
  endfunction

  assign seed_o = {(ctrl_i.pers_off ? {HALF_W{1'b0}} : pers_i),
                   pick_low(ctrl_i, ext_i, test_i, entropy_i)};
endmodule

// File: rtl/seed_assembler.sv
module seed_assembler
  import seed_pkg::*;
#(
  parameter int HALF_WORDS = 12,
  parameter int TEST_BITS  = 128,
  localparam int HALF_W    = HALF_WORDS * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                legacy_rev_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [WORD_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [WORD_W-1:0]   rd_data_o,
  input  logic [WORD_W-1:0]   status_i,
  input  logic [HALF_W-1:0]   entropy_i,
  output logic [2*HALF_W-1:0] seed_o,
  output logic                reseed_o,
  output logic                regen_o
);
  ctrl_t                ctrl_w;
  logic                 hold_w, osc_w, serial_wr_w, accept_w;
  logic [HALF_W-1:0]    ext_w, pers_w;
  logic [TEST_BITS-1:0] test_seed_w;

  seed_ctl_regs u_ctl (
    .clk(clk), .rst_n(rst_n), .legacy_rev_i(legacy_rev_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_byte_i(wr_data_i[CTRL_W-1:0]),
    .ctrl_o(ctrl_w), .hold_o(hold_w), .osc_o(osc_w),
    .serial_wr_o(serial_wr_w)
  );

  seed_word_bank #(.WORDS(HALF_WORDS), .BASE(A_EXT)) u_ext (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .bank_o(ext_w)
  );

  seed_word_bank #(.WORDS(HALF_WORDS), .BASE(A_PERS)) u_pers (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .bank_o(pers_w)
  );

  assign accept_w = serial_wr_w && ctrl_w.test_mode &&
                    source_live(ctrl_w, hold_w, osc_w);

  test_shift #(.TEST_BITS(TEST_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .bit_i(wr_data_i[0]),
    .seed_o(test_seed_w), .reseed_o(reseed_o), .regen_o(regen_o)
  );

  seed_mux #(.HALF_WORDS(HALF_WORDS), .TEST_BITS(TEST_BITS)) u_mux (
    .ctrl_i(ctrl_w), .ext_i(ext_w), .pers_i(pers_w), .test_i(test_seed_w),
    .entropy_i(entropy_i), .seed_o(seed_o)
  );

  always_comb begin
    if (in_hidden(rd_addr_i)) rd_data_o = status_i;
    else begin
      case (rd_addr_i)
        A_CTRL:  rd_data_o = {{(WORD_W-CTRL_W){1'b0}}, ctrl_w};
        A_STAT:  rd_data_o = status_i;
        A_HOLD:  rd_data_o = {{(WORD_W-1){1'b0}}, hold_w};
        A_OSC:   rd_data_o = {{(WORD_W-1){1'b0}}, osc_w};
        default: rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/seed_assembler_chk.sv
module seed_assembler_chk
  import seed_pkg::*;
#(
  parameter int HALF_W    = 384,
  parameter int TEST_BITS = 128
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 legacy_rev_i,
  input logic                 wr_en_i,
  input logic [ADDR_W-1:0]    wr_addr_i,
  input logic [WORD_W-1:0]    wr_data_i,
  input logic [ADDR_W-1:0]    rd_addr_i,
  input logic [WORD_W-1:0]    rd_data_o,
  input logic [WORD_W-1:0]    status_i,
  input logic [2*HALF_W-1:0]  seed_o,
  input logic                 reseed_o,
  input logic                 regen_o,
  input logic                 accept_w,
  input ctrl_t                ctrl_w,
  input logic [TEST_BITS-1:0] test_seed_w
);
  // R5
  reseed_then_regen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reseed_o |=> regen_o);
  // R5
  reseed_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reseed_o |-> $past(accept_w));
  // R3
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> test_seed_w == {$past(test_seed_w[TEST_BITS-2:0]), $past(wr_data_i[0])});
  // R4
  hold_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_w |=> $stable(test_seed_w));
  // R2
  pers_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w.pers_off |-> seed_o[2*HALF_W-1:HALF_W] == '0);
  // R6
  hidden_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i >= A_HIDE_LO && rd_addr_i <= A_HIDE_HI) |-> rd_data_o == status_i);
  // R7
  legacy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_CTRL && legacy_rev_i) |=> !ctrl_w.pers_off && !ctrl_w.one_shot);
  // R7
  newer_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == A_CTRL && !legacy_rev_i) |=> !ctrl_w.health_en && !ctrl_w.auto_adapt);
endmodule

bind seed_assembler seed_assembler_chk #(.HALF_W(HALF_W), .TEST_BITS(TEST_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .legacy_rev_i(legacy_rev_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o), .status_i(status_i), .seed_o(seed_o),
  .reseed_o(reseed_o), .regen_o(regen_o), .accept_w(accept_w),
  .ctrl_w(ctrl_w), .test_seed_w(test_seed_w)
);

// File: tb/tb_seed_assembler.sv
module tb_seed_assembler;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         legacy_rev_i = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [5:0]   wr_addr_i = '0;
  logic [31:0]  wr_data_i = '0;
  logic [5:0]   rd_addr_i = '0;
  logic [31:0]  rd_data_o;
  logic [31:0]  status_i = 32'h5A5A_0001;
  logic [383:0] entropy_i;
  logic [767:0] seed_o;
  logic         reseed_o, regen_o;

  int checks = 0;
  int errors = 0;
  logic [127:0] m_ts;
  logic [383:0] m_ext, m_pers;
  bit done = 0;

  seed_assembler dut (.*);

  always #10 clk = ~clk;

  initial begin
    for (int i = 0; i < 12; i++) entropy_i[i*32 +: 32] = 32'hE000_0000 + i * 32'h0011_0203;
  end

  task automatic chk(input logic [767:0] act, input logic [767:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_addr_i = a; #1; d = rd_data_o;
  endtask

  // serial write with expected acceptance, strobe timing checked (R4, R5)
  task automatic ser(input logic b, input logic exp_acc, input string tag);
    wr(6'h02, {31'h7FFF_FFFF, b});
    chk(reseed_o, exp_acc, {tag, " R5 reseed"});
    if (exp_acc) m_ts = {m_ts[126:0], b};
    @(negedge clk);
    chk({reseed_o, regen_o}, {1'b0, exp_acc}, {tag, " R5 regen"});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    m_ts = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk({reseed_o, regen_o}, 2'b00, "R8 strobes");
    rd(6'h00, r); chk(r, 32'h0, "R8 ctrl");
    rd(6'h03, r); chk(r, 32'h1, "R8 hold reg");
    rd(6'h04, r); chk(r, 32'h0, "R8 osc");
    chk(seed_o[767:384], '0, "R8 pers words");
    chk(seed_o[383:0], entropy_i, "R1 entropy default");
    wr(6'h00, 32'h08);
    chk(seed_o[383:0], '0, "R8 test seed zero");

    // R4 sweep of all five gates
    for (int c = 0; c < 32; c++) begin
      logic acc;
      wr(6'h03, {31'h0, c[0]});
      wr(6'h04, {31'h0, c[1]});
      wr(6'h00, {28'h0, c[2], 1'b0, c[3], c[4]});
      acc = !c[0] && c[1] && c[2] && c[3] && !c[4];
      ser(c[0] ^ c[3] ^ 1'b1, acc, "R4 gate sweep");
    end
    wr(6'h03, 0); wr(6'h04, 1); wr(6'h00, 32'h0A);
    chk(seed_o[383:0], {256'h0, m_ts}, "R4 seed after sweep");

    // R3 long shift sweep
    for (int i = 0; i < 140; i++) begin
      ser(((i * 7 + 3) % 5) < 2, 1'b1, "R3 shift");
      chk(seed_o[383:0], {256'h0, m_ts}, "R3 seed value");
    end

    // R1 / R9 external seed priority
    for (int i = 0; i < 12; i++) begin
      m_ext[i*32 +: 32] = 32'h1000_0000 + i * 32'h0101_0101;
      wr(6'h10 + 6'(i), m_ext[i*32 +: 32]);
    end
    wr(6'h00, 32'h0E);
    chk(seed_o[383:0], m_ext, "R9 ext word order");
    wr(6'h00, 32'h06);
    chk(seed_o[383:0], m_ext, "R1 ext without test");
    wr(6'h00, 32'h0A);
    chk(seed_o[383:0], {256'h0, m_ts}, "R1 test over entropy");
    wr(6'h00, 32'h02);
    chk(seed_o[383:0], entropy_i, "R1 entropy last");

    // R2 personalization
    for (int i = 0; i < 12; i++) begin
      m_pers[i*32 +: 32] = 32'hC0DE_0000 ^ (i * 32'h0003_0011);
      wr(6'h20 + 6'(i), m_pers[i*32 +: 32]);
    end
    chk(seed_o[767:384], m_pers, "R2 pers words");
    wr(6'h00, 32'h42);
    chk(seed_o[767:384], '0, "R2 pers disabled");
    rd(6'h00, r); chk(r, 32'h42, "R2 ctrl readback");

    // R6 hidden range
    for (int a = 16; a < 48; a++) begin
      status_i = 32'h5A00_0000 + a;
      rd(6'(a), r); chk(r, status_i, "R6 hidden read");
    end
    rd(6'h01, r); chk(r, status_i, "R6 status read");

    // R7 revision masking
    legacy_rev_i = 1'b1;
    wr(6'h00, 32'hFF);
    rd(6'h00, r); chk(r, 32'h3F, "R7 legacy mask");
    chk(seed_o[767:384], m_pers, "R7 legacy pers kept");
    legacy_rev_i = 1'b0;
    wr(6'h00, 32'hFF);
    rd(6'h00, r); chk(r, 32'hCF, "R7 newer mask");
    ser(1'b1, 1'b0, "R4 soft reset blocks");

    // R8 reset clears test seed
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_ts = '0;
    wr(6'h00, 32'h08);
    chk(seed_o, '0, "R8 seed after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule